// File: doc/BRIEF.md
# Lockstep Serial-Converter Capture with Time-Slotted Stream Output

This block reads a bank of single-channel serial converters together and sends their results out on one stream. The converters share one serial clock, one active-low select and one conversion strobe, so they all sample at the same moment. Each converter has its own data return line, and each line feeds its own shift register. Every frame works the same way. The block pulses the strobe and waits a fixed conversion time. It then pulls the select low and shifts in `SAMPLE_W` bits, most significant bit first, on the rising edges of the serial clock. The serial clock runs at the system clock divided by the even number `SCLK_DIV`. A new frame starts every `FRAME_PERIOD` system cycles.

When a frame completes, all the captured words are copied into a holding bank. The bank is then sent as `N_CH` slots on a `SAMPLE_W`-bit AXI4-Stream, channel 0 first. TUSER marks the first slot and TLAST marks the last slot. If a new frame completes while the bank is still being sent, that frame is discarded and a sticky overrun flag is set. The stream therefore always carries whole frames. The enable input only takes effect at a frame start. The global reset is synchronous and is retimed inside the block.

The frame sequencer has five states. SEQ_IDLE waits for the period tick. On that tick, if enable is high, it moves to SEQ_CONV. SEQ_CONV is a one-cycle strobe state that always moves to SEQ_WAIT. SEQ_WAIT counts `CONV_CYCLES` cycles and then moves to SEQ_SHIFT. SEQ_SHIFT holds the select low and moves to SEQ_DONE after the falling edge that follows the last rising edge. SEQ_DONE is one cycle and moves back to SEQ_IDLE.

The output sequencer has two states. OUT_EMPTY moves to OUT_SEND when a frame is accepted. OUT_SEND moves back to OUT_EMPTY when the last slot is handed over. If a new frame is accepted in that same cycle, it stays in OUT_SEND.

Top module: `adc_tdm_capture`

## Requirements
- R1: While reset is asserted, and in the cycle right after it, `m_tvalid`, `adc_convst`, `spi_sclk` and `overrun` are 0 and `spi_cs_n` is 1.
- R2: In every frame, `spi_sclk` makes exactly `SAMPLE_W` rising edges while `spi_cs_n` is low, and stays low whenever `spi_cs_n` is high. Each high phase lasts `SCLK_DIV/2` system cycles. Every channel samples its own data line on the same rising edges, MSB first, so the word for channel c equals the bits the converter presented in that order.
- R3: `adc_convst` is a one-cycle pulse. `spi_cs_n` falls `CONV_CYCLES+1` cycles after the pulse cycle. Pulses are spaced at whole multiples of `FRAME_PERIOD` cycles, and exactly `FRAME_PERIOD` apart while enable stays high.
- R4: A frame goes out as `N_CH` beats in channel order 0 to `N_CH-1`. `m_tuser` is 1 on slot 0 only, `m_tlast` is 1 on slot `N_CH-1` only, and `m_tdata` on slot c is channel c's word.
- R5: The slot advances only on a cycle with `m_tvalid` and `m_tready` both 1. While `m_tready` is 0, `m_tvalid` stays 1 and the data and markers do not change.
- R6: A frame that completes while the bank still holds unsent slots is dropped, unless its completion falls in the same cycle as the handshake of the last slot. A dropped frame sets `overrun`, which stays 1 until reset. Later output still starts with TUSER on channel 0, and it skips the dropped frames.
- R7: `enable` is sampled only at the period tick. If it is low there, no strobe is issued. If it falls in the middle of a frame, that frame still completes and is delivered, and no further strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Global synchronous reset, active high |
| enable | input | 1 | Acquisition run request, taken at frame start |
| adc_convst | output | 1 | Shared conversion strobe |
| spi_cs_n | output | 1 | Shared active-low select |
| spi_sclk | output | 1 | Shared serial clock |
| spi_miso | input | N_CH | One serial data line per converter |
| m_tdata | output | SAMPLE_W | Stream data, one channel word per beat |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tuser | output | 1 | First-slot marker |
| m_tlast | output | 1 | Last-slot marker |
| overrun | output | 1 | Sticky flag set when a frame was dropped |

## Verification
The hardest case to reach from the ports is a dropped frame. The sink has to hold the bank longer than a full frame period and then release it. Only after that can the bench see whether the next accepted frame skips the dropped converter results and still starts on channel 0. The bench holds `m_tready` low for several periods, checks that the held first slot stays put, and then drains the stream. A frame number is encoded in each converter's reply, so the gap in frame numbers can be seen on the stream. A second hard case is dropping `enable` while the select is low. The bench waits for the select to fall, waits past the previous frame's drain, and then drops `enable`. It then checks that exactly one more frame is delivered.

// File: rtl/adc_tdm_pkg.sv
package adc_tdm_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CONV,
        SEQ_WAIT,
        SEQ_SHIFT,
        SEQ_DONE
    } seq_state_t;

    typedef enum logic {
        OUT_EMPTY,
        OUT_SEND
    } out_state_t;

endpackage

// File: rtl/adc_reset_sync.sv
module adc_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        pipe_q <= {pipe_q[STAGES-2:0], rst_in};
    end

    // Asserts with the global request at once, releases STAGES cycles later.
    assign rst_out = rst_in | (|pipe_q);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_tdm_pkg::*;
#(
    parameter int SAMPLE_W     = 24,
    parameter int SCLK_DIV     = 4,
    parameter int CONV_CYCLES  = 1,
    parameter int FRAME_PERIOD = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic adc_convst,
    output logic spi_cs_n,
    output logic spi_sclk,
    output logic sample_stb,
    output logic frame_done
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int PW   = $clog2(FRAME_PERIOD);
    localparam int DW   = $clog2(HALF) + 1;
    localparam int WW   = $clog2(CONV_CYCLES) + 1;
    localparam int BW   = $clog2(SAMPLE_W + 1);

    seq_state_t    state_q, state_d;
    logic [PW-1:0] period_cnt;
    logic [WW-1:0] wait_cnt;
    logic [DW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;
    logic          sclk_q;
    logic          period_tick;
    logic          half_end;

    assign period_tick = (period_cnt == PW'(FRAME_PERIOD - 1));
    assign half_end    = (div_cnt == DW'(HALF - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (period_tick && enable) state_d = SEQ_CONV;
            SEQ_CONV:  state_d = SEQ_WAIT;
            SEQ_WAIT:  if (wait_cnt == WW'(CONV_CYCLES - 1)) state_d = SEQ_SHIFT;
            SEQ_SHIFT: if (half_end && sclk_q && bit_cnt == BW'(SAMPLE_W)) state_d = SEQ_DONE;
            SEQ_DONE:  state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // Period, conversion-wait, divider and bit counters
    always_ff @(posedge clk) begin
        if (rst) begin
            period_cnt <= '0;
            wait_cnt   <= '0;
            div_cnt    <= '0;
            bit_cnt    <= '0;
            sclk_q     <= 1'b0;
        end else begin
            period_cnt <= period_tick ? '0 : period_cnt + 1'b1;
            wait_cnt   <= (state_q == SEQ_WAIT) ? wait_cnt + 1'b1 : '0;
            if (state_q == SEQ_SHIFT) begin
                if (half_end) begin
                    div_cnt <= '0;
                    sclk_q  <= ~sclk_q;
                    if (!sclk_q) bit_cnt <= bit_cnt + 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end else begin
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk_q  <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        adc_convst = 1'b0;
        spi_cs_n   = 1'b1;
        frame_done = 1'b0;
        sample_stb = 1'b0;
        unique case (state_q)
            SEQ_CONV:  adc_convst = 1'b1;
            SEQ_SHIFT: begin
                spi_cs_n   = 1'b0;
                sample_stb = half_end && !sclk_q;
            end
            SEQ_DONE:  frame_done = 1'b1;
            default:   ;
        endcase
    end

    assign spi_sclk = sclk_q;

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R2
    AST_FULL_WORD_SHIFTED: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (bit_cnt == BW'(SAMPLE_W))); // R2
    AST_CONVST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        adc_convst |=> !adc_convst); // R3
    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_convst) |-> $past(enable)); // R7

endmodule

// File: rtl/adc_shift_lane.sv
module adc_shift_lane #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_stb,
    input  logic                miso,
    output logic [SAMPLE_W-1:0] word
);
    logic [SAMPLE_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)             sr_q <= '0;
        else if (sample_stb) sr_q <= {sr_q[SAMPLE_W-2:0], miso};
    end

    assign word = sr_q;

endmodule

// File: rtl/adc_tdm_out.sv
module adc_tdm_out
    import adc_tdm_pkg::*;
#(
    parameter int N_CH     = 32,
    parameter int SAMPLE_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_done,
    input  logic [N_CH*SAMPLE_W-1:0] lane_words,
    output logic [SAMPLE_W-1:0]      m_tdata,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic                     m_tuser,
    output logic                     m_tlast,
    output logic                     overrun
);
    localparam int SW = $clog2(N_CH);

    out_state_t          state_q, state_d;
    logic [SW-1:0]       slot_q;
    logic [SAMPLE_W-1:0] bank_q [N_CH];
    logic                last_slot, hs, accept;

    assign last_slot = (slot_q == SW'(N_CH - 1));
    assign hs        = (state_q == OUT_SEND) && m_tready;
    assign accept    = frame_done && ((state_q == OUT_EMPTY) || (hs && last_slot));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_EMPTY;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (accept) state_d = OUT_SEND;
            OUT_SEND:  if (hs && last_slot && !accept) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    // Holding bank, slot pointer and sticky drop flag
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept)  slot_q <= '0;
            else if (hs) slot_q <= slot_q + 1'b1;
            if (frame_done && !accept) overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < N_CH; i++) bank_q[i] <= lane_words[i*SAMPLE_W +: SAMPLE_W];
        end
    end

    // Outputs
    always_comb begin
        m_tvalid = 1'b0;
        m_tuser  = 1'b0;
        m_tlast  = 1'b0;
        m_tdata  = bank_q[slot_q];
        unique case (state_q)
            OUT_SEND: begin
                m_tvalid = 1'b1;
                m_tuser  = (slot_q == '0);
                m_tlast  = last_slot;
            end
            default: ;
        endcase
    end

    AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast))); // R5
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R6
    AST_MARKERS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(m_tuser && m_tlast)); // R4
    AST_MARKER_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (m_tuser || m_tlast) |-> m_tvalid); // R4

endmodule

// File: rtl/adc_tdm_capture.sv
module adc_tdm_capture #(
    parameter int N_CH         = 32,
    parameter int SAMPLE_W     = 24,
    parameter int SCLK_DIV     = 4,
    parameter int CONV_CYCLES  = 1,
    parameter int FRAME_PERIOD = 100
) (
    input  logic                clk,
    input  logic                rst_in,
    input  logic                enable,
    output logic                adc_convst,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    input  logic [N_CH-1:0]     spi_miso,
    output logic [SAMPLE_W-1:0] m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tuser,
    output logic                m_tlast,
    output logic                overrun
);
    logic                     rst_local;
    logic                     sample_stb;
    logic                     frame_done;
    logic [N_CH*SAMPLE_W-1:0] lane_words;

    adc_reset_sync #(.STAGES(2)) u_rst (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_out (rst_local)
    );

    adc_frame_seq #(
        .SAMPLE_W     (SAMPLE_W),
        .SCLK_DIV     (SCLK_DIV),
        .CONV_CYCLES  (CONV_CYCLES),
        .FRAME_PERIOD (FRAME_PERIOD)
    ) u_seq (
        .clk        (clk),
        .rst        (rst_local),
        .enable     (enable),
        .adc_convst (adc_convst),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .sample_stb (sample_stb),
        .frame_done (frame_done)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        adc_shift_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk        (clk),
            .rst        (rst_local),
            .sample_stb (sample_stb),
            .miso       (spi_miso[c]),
            .word       (lane_words[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    adc_tdm_out #(
        .N_CH     (N_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst_local),
        .frame_done (frame_done),
        .lane_words (lane_words),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tuser    (m_tuser),
        .m_tlast    (m_tlast),
        .overrun    (overrun)
    );

endmodule

// File: tb/adc_tdm_capture_bench.sv
module adc_tdm_capture_bench;
    localparam int N    = 32;
    localparam int W    = 24;
    localparam int DIV  = 4;
    localparam int CONV = 1;
    localparam int PER  = 100;

    logic         clk = 1'b0;
    logic         rst_in = 1'b1;
    logic         enable = 1'b0;
    logic         adc_convst, spi_cs_n, spi_sclk;
    logic [N-1:0] spi_miso = '0;
    logic [W-1:0] m_tdata;
    logic         m_tvalid, m_tuser, m_tlast, overrun;
    logic         m_tready = 1'b1;

    adc_tdm_capture #(
        .N_CH(N), .SAMPLE_W(W), .SCLK_DIV(DIV), .CONV_CYCLES(CONV), .FRAME_PERIOD(PER)
    ) u_adc_tdm_capture (
        .clk(clk), .rst_in(rst_in), .enable(enable),
        .adc_convst(adc_convst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_miso(spi_miso),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast), .overrun(overrun)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Converter model: word carries frame number, channel and a mix of both
    function automatic logic [W-1:0] pat(input int f, input int ch);
        logic [7:0] mix;
        mix = 8'(ch * 37 + f * 11 + 90);
        return {8'(f), 8'(ch), mix};
    endfunction

    int conv_count = 0;
    int frame_fid = 0;
    logic [W-1:0] mdl [N];

    always @(posedge adc_convst) begin
        frame_fid = conv_count;
        conv_count++;
    end

    initial begin
        forever begin
            @(negedge spi_cs_n);
            for (int ch = 0; ch < N; ch++) begin
                mdl[ch] = pat(frame_fid, ch);
                spi_miso[ch] = mdl[ch][W-1];
            end
            while (1) begin
                @(negedge spi_sclk or posedge spi_cs_n);
                if (spi_cs_n) break;
                for (int ch = 0; ch < N; ch++) begin
                    mdl[ch] = {mdl[ch][W-2:0], 1'b0};
                    spi_miso[ch] = mdl[ch][W-1];
                end
            end
        end
    end

    // Sink ready pattern: 0 always ready, 1 ready two cycles of three, 2 never ready
    int rdy_mode = 0;
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       m_tready = 1'b1;
            1:       m_tready = (cyc % 3) != 2;
            default: m_tready = 1'b0;
        endcase
    end

    // Monitors, sampled on the falling edge
    int mon_slot = 0, mon_fid = 0, last_fid = -1, gaps = 0, frames_rx = 0, beats = 0;
    int prev_conv = -1, conv_at = -1, conv_seen = 0, sclk_rises = 0, hi_len = 0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0, stall_pend = 1'b0;
    logic [W-1:0] stall_data = '0;

    always @(negedge clk) begin
        if (rst_in) begin
            mon_slot = 0; last_fid = -1; prev_conv = -1; conv_at = -1;
            sclk_rises = 0; hi_len = 0; stall_pend = 1'b0;
            cs_prev = 1'b1; sclk_prev = 1'b0;
        end else begin
            if (stall_pend) begin
                chk(m_tvalid && m_tdata == stall_data, "R5", "held beat under stall", m_tdata, stall_data);
            end
            stall_pend = m_tvalid && !m_tready;
            stall_data = m_tdata;

            if (m_tvalid && m_tready) begin
                beats++;
                if (mon_slot == 0) begin
                    mon_fid = int'(m_tdata[W-1:W-8]);
                    if (last_fid >= 0 && mon_fid != ((last_fid + 1) & 255)) gaps++;
                end
                chk(m_tuser == (mon_slot == 0), "R4", "tuser on slot", m_tuser, mon_slot == 0);
                chk(m_tlast == (mon_slot == N-1), "R4", "tlast on slot", m_tlast, mon_slot == N-1);
                chk(m_tdata == pat(mon_fid, mon_slot), "R2", "channel word in slot", m_tdata, pat(mon_fid, mon_slot));
                if (mon_slot == N-1) begin
                    last_fid = mon_fid;
                    frames_rx++;
                    mon_slot = 0;
                end else begin
                    mon_slot++;
                end
            end

            if (adc_convst) begin
                conv_seen++;
                if (prev_conv >= 0)
                    chk((cyc - prev_conv) % PER == 0, "R3", "strobe spacing", cyc - prev_conv, PER);
                prev_conv = cyc;
                conv_at = cyc;
            end
            if (cs_prev && !spi_cs_n && conv_at >= 0)
                chk(cyc - conv_at == CONV + 1, "R3", "strobe to select", cyc - conv_at, CONV + 1);
            if (!spi_cs_n && spi_sclk && !sclk_prev) sclk_rises++;
            if (spi_sclk) hi_len++;
            else begin
                if (hi_len != 0) chk(hi_len == DIV/2, "R2", "sclk high phase", hi_len, DIV/2);
                hi_len = 0;
            end
            if (!cs_prev && spi_cs_n) begin
                chk(sclk_rises == W, "R2", "sclk rises per frame", sclk_rises, W);
                sclk_rises = 0;
            end
            cs_prev = spi_cs_n;
            sclk_prev = spi_sclk;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frames(input int k);
        int start = frames_rx;
        for (int i = 0; i < k * PER * 4 && frames_rx - start < k; i++) step(1);
    endtask

    task automatic t_reset();
        rst_in = 1'b1;
        step(4);
        chk(!m_tvalid && !adc_convst && !spi_sclk && !overrun && spi_cs_n, "R1", "outputs in reset",
            {m_tvalid, adc_convst, spi_sclk, overrun, spi_cs_n}, 5'b00001);
        rst_in = 1'b0;
        step(1);
        chk(!m_tvalid && !adc_convst && !overrun && spi_cs_n, "R1", "outputs after release",
            {m_tvalid, adc_convst, overrun, spi_cs_n}, 4'b0001);
        step(2);
    endtask

    task automatic t_idle_disabled();
        int c0 = conv_seen, b0 = beats;
        enable = 1'b0;
        rdy_mode = 0;
        step(3 * PER);
        chk(conv_seen == c0, "R7", "no strobe while disabled", conv_seen - c0, 0);
        chk(beats == b0, "R7", "no beats while disabled", beats - b0, 0);
    endtask

    task automatic t_stream_basic();
        int f0 = frames_rx, g0 = gaps;
        rdy_mode = 0;
        enable = 1'b1;
        wait_frames(4);
        chk(frames_rx - f0 >= 4, "R4", "frames delivered", frames_rx - f0, 4);
        chk(gaps == g0, "R6", "no skipped frame with free sink", gaps - g0, 0);
        chk(!overrun, "R6", "overrun clear", overrun, 0);
    endtask

    task automatic t_backpressure();
        int f0 = frames_rx, g0 = gaps;
        rdy_mode = 1;
        wait_frames(4);
        chk(frames_rx - f0 >= 4, "R5", "frames under throttled sink", frames_rx - f0, 4);
        chk(gaps == g0 && !overrun, "R5", "no drop under throttle", gaps - g0, 0);
        rdy_mode = 0;
    endtask

    task automatic t_overrun();
        int g0 = gaps, f0;
        rdy_mode = 2;
        step(3 * PER + 20);
        chk(overrun, "R6", "overrun after stalled frames", overrun, 1);
        chk(m_tvalid && m_tuser, "R5", "first slot held", {m_tvalid, m_tuser}, 2'b11);
        rdy_mode = 0;
        f0 = frames_rx;
        wait_frames(3);
        chk(frames_rx - f0 >= 3, "R6", "stream resumes", frames_rx - f0, 3);
        chk(gaps > g0, "R6", "dropped frames skipped", gaps - g0, 1);
        chk(overrun, "R6", "overrun sticky", overrun, 1);
    endtask

    task automatic t_enable_midframe();
        int f0, c0, g0;
        rdy_mode = 0;
        enable = 1'b1;
        for (int i = 0; i < 4 * PER && spi_cs_n; i++) step(1);
        step(40);
        enable = 1'b0;
        f0 = frames_rx; c0 = conv_seen; g0 = gaps;
        step(3 * PER);
        chk(frames_rx - f0 == 1, "R7", "in-flight frame delivered", frames_rx - f0, 1);
        chk(conv_seen == c0, "R7", "no strobe after disable", conv_seen - c0, 0);
        enable = 1'b1;
        wait_frames(2);
        chk(gaps == g0, "R7", "frames continuous after re-enable", gaps - g0, 0);
    endtask

    task automatic t_reset_midstream();
        enable = 1'b0;
        rdy_mode = 2;
        step(2 * PER);
        chk(m_tvalid && overrun, "R1", "pending beat and flag before reset", {m_tvalid, overrun}, 2'b11);
        t_reset();
        rdy_mode = 0;
    endtask

    initial begin
        t_reset();
        t_idle_disabled();
        t_stream_basic();
        t_backpressure();
        t_overrun();
        t_enable_midframe();
        t_reset_midstream();
        summary();
        $finish;
    end

endmodule